// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level forward-mapped page table in memory. Pages are 1 KB. The ten low address bits pass through unchanged as the page offset. The next ten bits index an inner table of frame entries. The top twelve bits index an outer table, and each valid outer entry points at one inner table.

A requester offers one address at a time and waits for the answer. The walker first compares the outer index against a programmable length bound. It then issues up to two reads, one at a time, on a simple memory port: a one-cycle request pulse with an address, answered later by a data-valid strobe. An entry is 32 bits wide. Bit 0 is its valid flag, and bits 31:10 hold a 1 KB aligned base for a table or a frame.

The walk ends with a one-cycle response. That response carries either the physical address or a fault cause that names the level at which the walk stopped.

Top module: `ptw_top`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the response has been given, and any `req_valid`/`req_va` activity in that time has no effect.
- R2: The accepted address is split as outer index = `va[31:20]`, inner index = `va[19:10]` and offset = `va[9:0]`.
- R3: The first read of a walk goes to `ptbr + 4 * outer index`.
- R4: The second read goes to `{outer_entry[31:10], 10'b0} + 4 * inner index`. Bits 9:1 of an entry are ignored.
- R5: When both entries have bit 0 set, the response has `resp_cause` = 0 and `resp_pa` = `{inner_entry[31:10], va[9:0]}`, after exactly two reads.
- R6: When the outer index is greater than or equal to `outer_len`, the response comes in the cycle right after acceptance with `resp_cause` = 1, and no memory read is issued.
- R7: When the outer entry has bit 0 clear, the walk ends with `resp_cause` = 2 after exactly one read.
- R8: When the inner entry has bit 0 clear, the walk ends with `resp_cause` = 3 after exactly two reads.
- R9: On any fault (`resp_cause` other than 0), `resp_pa` reads zero.
- R10: `mem_req` and `resp_valid` are single-cycle pulses. A `mem_rvalid` strobe that arrives while no read is outstanding is ignored.
- R11: While reset is held, the walker is idle: `req_ready` = 1, `mem_req` = 0 and `resp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr | input | 32 | Byte address of the outer table |
| outer_len | input | 13 | Number of usable outer entries; indices at or above it fault |
| req_valid | input | 1 | Translation request offered |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_cause | output | 2 | 0 ok, 1 outer index out of bound, 2 outer entry invalid, 3 inner entry invalid |
| resp_pa | output | 32 | Physical address, zero on a fault |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry returned by memory |

## Verification
The hardest case to reach from the ports is a walk that stops at one level while the other level's data would have been good, with the wrong read count hidden behind a correct-looking cause. The bench's memory model builds every outer and inner entry arithmetically from its indices, so it can mark chosen outer slots invalid and chosen inner slots invalid independently. It also plants junk in bits 9:1 of every entry. The sweep covers outer indices on both sides of the length bound, combined with inner indices that hit valid and invalid slots. Each combination runs with varied memory latency, with a changing address held on the request port during the walk, and with counts of every issued read and its address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD_OUTER,
    WS_WT_OUTER,
    WS_RD_INNER,
    WS_WT_INNER,
    WS_DONE
  } walk_state_t;

  typedef enum logic [1:0] {
    WC_OK        = 2'd0,
    WC_BOUND     = 2'd1,
    WC_OUTER_INV = 2'd2,
    WC_INNER_INV = 2'd3
  } walk_cause_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W        = 32,
  parameter int PTE_W       = 32,
  parameter int OFF_W       = 10,
  parameter int INNER_W     = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [VA_W-1:0]        va,
  input  logic [PTE_W-1:0]       ptbr,
  input  logic [PTE_W-OFF_W-1:0] tbl_base,
  input  logic [PTE_W-OFF_W-1:0] frame,
  output logic [PTE_W-1:0]       outer_addr,
  output logic [PTE_W-1:0]       inner_addr,
  output logic [PTE_W-1:0]       pa
);

  localparam int OUTER_W = VA_W - INNER_W - OFF_W;

  logic [OUTER_W-1:0] outer_idx;
  logic [INNER_W-1:0] inner_idx;

  assign outer_idx = va[VA_W-1 -: OUTER_W];
  assign inner_idx = va[OFF_W +: INNER_W];

  // entry byte address = table start + index scaled by entry size
  assign outer_addr = ptbr + PTE_W'({outer_idx, {ENTRY_SHIFT{1'b0}}});
  assign inner_addr = {tbl_base, {OFF_W{1'b0}}} + PTE_W'({inner_idx, {ENTRY_SHIFT{1'b0}}});
  assign pa         = {frame, va[OFF_W-1:0]};

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       bound_fail,
  input  logic       mem_rvalid,
  input  logic       entry_valid,
  output logic       req_ready,
  output logic       accept,
  output logic       outer_take,
  output logic       inner_take,
  output logic       mem_req,
  output logic       sel_inner,
  output logic       resp_valid,
  output logic [1:0] resp_cause
);

  walk_state_t state_q, state_d;
  walk_cause_t cause_q, cause_d;
  logic        cause_en;

  always_comb begin
    state_d  = state_q;
    cause_d  = cause_q;
    cause_en = 1'b0;
    case (state_q)
      WS_IDLE: begin
        if (req_valid) begin
          cause_en = 1'b1;
          if (bound_fail) begin
            state_d = WS_DONE;
            cause_d = WC_BOUND;
          end else begin
            state_d = WS_RD_OUTER;
            cause_d = WC_OK;
          end
        end
      end
      WS_RD_OUTER: state_d = WS_WT_OUTER;
      WS_WT_OUTER: begin
        if (mem_rvalid) begin
          if (entry_valid) begin
            state_d = WS_RD_INNER;
          end else begin
            state_d  = WS_DONE;
            cause_d  = WC_OUTER_INV;
            cause_en = 1'b1;
          end
        end
      end
      WS_RD_INNER: state_d = WS_WT_INNER;
      WS_WT_INNER: begin
        if (mem_rvalid) begin
          state_d  = WS_DONE;
          cause_en = 1'b1;
          cause_d  = entry_valid ? WC_OK : WC_INNER_INV;
        end
      end
      WS_DONE: state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      cause_q <= WC_OK;
    end else begin
      state_q <= state_d;
      if (cause_en) begin
        cause_q <= cause_d;
      end
    end
  end

  assign req_ready  = (state_q == WS_IDLE);
  assign accept     = req_ready && req_valid;
  assign outer_take = (state_q == WS_WT_OUTER) && mem_rvalid && entry_valid;
  assign inner_take = (state_q == WS_WT_INNER) && mem_rvalid && entry_valid;
  assign mem_req    = (state_q == WS_RD_OUTER) || (state_q == WS_RD_INNER);
  assign sel_inner  = (state_q == WS_RD_INNER);
  assign resp_valid = (state_q == WS_DONE);
  assign resp_cause = cause_q;

endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int VA_W    = 32,
  parameter int PTE_W   = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10,
  parameter int OUTER_W = VA_W - INNER_W - OFF_W,
  parameter int LEN_W   = OUTER_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTE_W-1:0]  ptbr,
  input  logic [LEN_W-1:0]  outer_len,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [1:0]        resp_cause,
  output logic [PTE_W-1:0]  resp_pa,
  output logic              mem_req,
  output logic [PTE_W-1:0]  mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata
);

  localparam int BASE_W      = PTE_W - OFF_W;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  logic              accept, outer_take, inner_take, sel_inner, bound_fail;
  logic [VA_W-1:0]   va_q;
  logic [BASE_W-1:0] tbl_q;
  logic [PTE_W-1:0]  pa_q, pa_next, outer_addr, inner_addr;
  wire               unused_pte_flags = ^mem_rdata[OFF_W-1:1];

  assign bound_fail = {1'b0, req_va[VA_W-1 -: OUTER_W]} >= outer_len;

  ptw_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .bound_fail  (bound_fail),
    .mem_rvalid  (mem_rvalid),
    .entry_valid (mem_rdata[0]),
    .req_ready   (req_ready),
    .accept      (accept),
    .outer_take  (outer_take),
    .inner_take  (inner_take),
    .mem_req     (mem_req),
    .sel_inner   (sel_inner),
    .resp_valid  (resp_valid),
    .resp_cause  (resp_cause)
  );

  ptw_addr_gen #(
    .VA_W        (VA_W),
    .PTE_W       (PTE_W),
    .OFF_W       (OFF_W),
    .INNER_W     (INNER_W),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) agen_i (
    .va         (va_q),
    .ptbr       (ptbr),
    .tbl_base   (tbl_q),
    .frame      (mem_rdata[PTE_W-1:OFF_W]),
    .outer_addr (outer_addr),
    .inner_addr (inner_addr),
    .pa         (pa_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      tbl_q <= '0;
      pa_q  <= '0;
    end else begin
      if (accept) begin
        va_q <= req_va;
      end
      if (outer_take) begin
        tbl_q <= mem_rdata[PTE_W-1:OFF_W];
      end
      if (accept) begin
        pa_q <= '0;
      end else if (inner_take) begin
        pa_q <= pa_next;
      end
    end
  end

  assign mem_addr = sel_inner ? inner_addr : outer_addr;
  assign resp_pa  = pa_q;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PTE_W   = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTE_W-1:0] ptbr,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_va,
  input logic             req_ready,
  input logic             resp_valid,
  input logic [1:0]       resp_cause,
  input logic [PTE_W-1:0] resp_pa,
  input logic             mem_req,
  input logic [PTE_W-1:0] mem_addr
);

  localparam int OUTER_W = VA_W - INNER_W - OFF_W;

  logic [1:0]      rd_cnt;
  logic [VA_W-1:0] va_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      va_c   <= '0;
    end else begin
      if (req_valid && req_ready) begin
        rd_cnt <= '0;
        va_c   <= req_va;
      end else if (mem_req && rd_cnt != 2'd3) begin
        rd_cnt <= rd_cnt + 2'd1;
      end
    end
  end

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_outer_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && rd_cnt == 2'd0) |->
      mem_addr == ptbr + PTE_W'({va_c[VA_W-1 -: OUTER_W], 2'b00}));

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_cause == WC_OK) |-> resp_pa[OFF_W-1:0] == va_c[OFF_W-1:0]);

  assert_bound_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_cause == WC_BOUND) |-> rd_cnt == 2'd0);

  assert_outer_fault_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_cause == WC_OUTER_INV) |-> rd_cnt == 2'd1);

  assert_two_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_cause == WC_OK || resp_cause == WC_INNER_INV)) |-> rd_cnt == 2'd2);

  assert_fault_pa_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_cause != WC_OK) |-> resp_pa == '0);

  assert_mem_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

endmodule

bind ptw_top ptw_checker #(
  .VA_W    (VA_W),
  .PTE_W   (PTE_W),
  .OFF_W   (OFF_W),
  .INNER_W (INNER_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ptbr       (ptbr),
  .req_valid  (req_valid),
  .req_va     (req_va),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_cause (resp_cause),
  .resp_pa    (resp_pa),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr)
);

// File: tb/ptw_top_tb_top.sv
`timescale 1ns/1ps
module ptw_top_tb_top;

  localparam logic [31:0] PTBR_VAL = 32'h0010_0000;
  localparam logic [31:0] INNER_RG = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ptbr;
  logic [12:0] outer_len;
  logic        req_valid;
  logic [31:0] req_va;
  logic        req_ready, resp_valid, mem_req;
  logic [1:0]  resp_cause;
  logic [31:0] resp_pa, mem_addr, mem_rdata;
  logic        mem_rvalid;

  logic        rsp_rv, spur_rv;
  logic [31:0] rsp_data, spur_data;
  int          errors = 0;
  int          checks = 0;
  int          reads;
  int          bad_addr = 0;
  int          lat = 0;
  bit          finished = 1'b0;
  logic [31:0] rd_addr [2];

  assign mem_rvalid = rsp_rv | spur_rv;
  assign mem_rdata  = rsp_rv ? rsp_data : spur_data;

  always #2.5 clk = ~clk;

  ptw_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptbr       (ptbr),
    .outer_len  (outer_len),
    .req_valid  (req_valid),
    .req_va     (req_va),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_cause (resp_cause),
    .resp_pa    (resp_pa),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] inner_base(int i);
    return INNER_RG + 32'(i) * 32'h1000;
  endfunction

  function automatic bit outer_ok(int i);
    return (i % 5) != 3;
  endfunction

  function automatic bit inner_ok(int j);
    return (j % 7) != 4;
  endfunction

  function automatic logic [21:0] frame_of(int i, int j);
    return 22'((i * 37 + j * 11 + 5) & 32'h3F_FFFF);
  endfunction

  // entries carry junk in bits 9:1 that the walker must ignore
  function automatic logic [31:0] outer_pte(int i);
    return inner_base(i) | 32'h2A8 | {31'b0, outer_ok(i)};
  endfunction

  function automatic logic [31:0] inner_pte(int i, int j);
    return {frame_of(i, j), 10'b0} | 32'h154 | {31'b0, inner_ok(j)};
  endfunction

  function automatic logic [31:0] mem_read(logic [31:0] a);
    if (a >= PTBR_VAL && a < PTBR_VAL + 32'h4000 && a[1:0] == 2'b00)
      return outer_pte(int'((a - PTBR_VAL) >> 2));
    else if (a >= INNER_RG && a < INNER_RG + 32'h0100_0000 && a[1:0] == 2'b00)
      return inner_pte(int'((a - INNER_RG) >> 12), int'((a >> 2) & 32'h3FF));
    bad_addr++;
    return 32'h0;
  endfunction

  // memory responder: answers each read after lat+1 cycles
  initial begin
    rsp_rv   = 1'b0;
    rsp_data = '0;
    reads    = 0;
    forever begin
      @(negedge clk);
      while (mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        if (reads < 2) rd_addr[reads] = a;
        reads++;
        repeat (lat + 1) @(negedge clk);
        rsp_data = mem_read(a);
        rsp_rv   = 1'b1;
        @(negedge clk);
        rsp_rv   = 1'b0;
      end
    end
  end

  task automatic walk(int i, int j, int off, int len, int lt);
    logic [31:0] va;
    logic [1:0]  exp_cause;
    logic [31:0] exp_pa;
    int          exp_reads;
    int          n;
    va = {i[11:0], j[9:0], off[9:0]};
    if (i >= len) begin
      exp_cause = 2'd1; exp_pa = 0; exp_reads = 0;
    end else if (!outer_ok(i)) begin
      exp_cause = 2'd2; exp_pa = 0; exp_reads = 1;
    end else if (!inner_ok(j)) begin
      exp_cause = 2'd3; exp_pa = 0; exp_reads = 2;
    end else begin
      exp_cause = 2'd0; exp_pa = {frame_of(i, j), off[9:0]}; exp_reads = 2;
    end
    @(negedge clk);
    outer_len = 13'(len);
    lat       = lt;
    reads     = 0;
    check_eq("R1", "ready when idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_va    = va;
    @(negedge clk);
    // R1: a different address offered during the walk must be ignored
    req_va = ~va;
    check_eq("R1", "ready low after accept", {31'b0, req_ready}, 32'd0);
    n = 0;
    while (!resp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check_eq("R10", "response before timeout", {31'b0, resp_valid}, 32'd1);
    if (exp_cause == 2'd1) begin
      check_eq("R6", "bound fault cause", {30'b0, resp_cause}, 32'd1);
      check_eq("R6", "bound response latency", 32'(n), 32'd0);
    end else if (exp_cause == 2'd2) begin
      check_eq("R7", "outer invalid cause", {30'b0, resp_cause}, 32'd2);
    end else if (exp_cause == 2'd3) begin
      check_eq("R8", "inner invalid cause", {30'b0, resp_cause}, 32'd3);
    end else begin
      check_eq("R5", "ok cause", {30'b0, resp_cause}, 32'd0);
    end
    if (exp_cause == 2'd0)
      check_eq("R5", "physical address", resp_pa, exp_pa);
    else
      check_eq("R9", "fault pa zero", resp_pa, 32'd0);
    check_eq(exp_cause == 2'd1 ? "R6" : (exp_cause == 2'd2 ? "R7" : "R8"),
             "read count", 32'(reads), 32'(exp_reads));
    if (reads >= 1)
      check_eq("R3", "outer read address", rd_addr[0], PTBR_VAL + 32'(i) * 4);
    if (reads >= 2)
      check_eq("R4", "inner read address", rd_addr[1], inner_base(i) + 32'(j) * 4);
    @(negedge clk);
    check_eq("R10", "response is one cycle", {31'b0, resp_valid}, 32'd0);
    check_eq("R1", "ready after response", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int jl [6];
    jl = '{0, 4, 11, 500, 1020, 1023};
    rst_n     = 1'b0;
    ptbr      = PTBR_VAL;
    outer_len = 13'd12;
    req_valid = 1'b0;
    req_va    = '0;
    spur_rv   = 1'b0;
    spur_data = '0;
    repeat (4) @(negedge clk);
    check_eq("R11", "reset ready", {31'b0, req_ready}, 32'd1);
    check_eq("R11", "reset mem_req", {31'b0, mem_req}, 32'd0);
    check_eq("R11", "reset resp_valid", {31'b0, resp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: a stray read strobe while idle does nothing
    spur_rv   = 1'b1;
    spur_data = 32'hFFFF_FFFF;
    @(negedge clk);
    spur_rv   = 1'b0;
    check_eq("R10", "stray rvalid no response", {31'b0, resp_valid}, 32'd0);
    check_eq("R10", "stray rvalid stays idle", {31'b0, req_ready}, 32'd1);
    check_eq("R10", "stray rvalid no read", {31'b0, mem_req}, 32'd0);

    // R2 sweep of outer and inner indices around the bound
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 6; k++) begin
        walk(i, jl[k], (i * 67 + jl[k]) & 32'h3FF, 12, (i + k) % 3);
      end
    end

    // boundary cases of the length register and offsets
    walk(0, 1, 0, 0, 0);            // zero length: every index faults
    walk(4095, 0, 10'h3FF, 4096, 1); // largest index, full length
    walk(4095, 0, 0, 4095, 2);       // largest index, just out of bound
    walk(11, 2, 10'h3FF, 12, 2);     // last index inside the bound
    walk(12, 2, 0, 13, 0);           // 12 % 5 = 2, allowed with longer bound

    check_eq("R4", "no stray memory addresses", 32'(bad_addr), 32'd0);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule